// File: doc/BRIEF.md
# Dual-Mode Watchdog and Interval Timer

This block is an eight-bit up-counter. It runs either as a periodic interval timer or as a system watchdog. An eight-bit control/status byte sets its behaviour. The byte holds an enable bit, a mode bit, a three-bit field that picks one of eight prescaled clock-enable inputs, and a sticky overflow flag. On each pulse of the selected enable, the counter steps by one. When it wraps from 0xFF to 0x00, the block does one of two things. In interval mode it raises a level interrupt towards the processor. In watchdog mode it drives a pulse, several clocks wide, on an external overflow pin.

Software reaches the block through a small register bus. Address 0 is the counter and address 1 is the control/status byte. Reads are combinational while the read strobe is high. Writes carry 16 bits. A write to the control/status byte takes effect only when the upper byte carries a fixed key, which guards against stray stores. Software services the watchdog by rewriting the counter before it wraps. A standby input clears the upper control bits and leaves the clock choice in place.

Top module: `wdt_top`

## Requirements
- R1: After reset the counter reads 0x00 and the control/status byte reads 0x18. Its layout is: bit 7 flag, bit 6 mode (1 = watchdog), bit 5 enable, bits 4 and 3 always read 1, bits 2..0 clock select. After reset both outputs are low.
- R2: A write to address 1 changes the control/status byte only when wdata[15:8] equals 0x5A. A write with any other upper byte leaves the byte unchanged. A write to address 0 loads wdata[7:0] into the counter with no key.
- R3: While enable is 1, the counter steps by one in each cycle where the clock-enable input picked by the clock-select field is high. The other clock-enable inputs have no effect.
- R4: While enable is 0, the counter holds its value whatever the clock-enable inputs do.
- R5: In interval mode, a wrap from 0xFF to 0x00 sets the flag in the next cycle. The interrupt output is high exactly while the flag is 1 and the mode bit is 0.
- R6: In watchdog mode, a wrap drives the overflow output high for PULSE_LEN cycles (default 4), starting in the cycle after the wrap. The flag stays 0.
- R7: A keyed write with bit 7 = 0 clears the flag only if the byte was read while the flag was 1 since the last keyed write. Without that read the flag stays set. Writing 1 to bit 7 never sets the flag.
- R8: While standby is high, the flag, the mode bit and the enable bit are forced to 0. The clock-select field keeps its value, and writes to the control/status byte are ignored.
- R9: A counter write in the same cycle as a selected enable pulse loads the written value. That cycle produces no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en_taps | input | 8 | Prescaled clock-enable pulses, one per clock-select code |
| standby | input | 1 | Standby request, level |
| addr | input | 1 | Register select: 0 counter, 1 control/status |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 16 | Write data; upper byte is the key for control writes |
| rdata | output | 8 | Read data, zero when rd_en is low |
| irq_interval | output | 1 | Interval-mode overflow interrupt, level |
| wdt_ovf_out | output | 1 | Watchdog overflow pulse |

## Verification
A wrong counter value shows within one enable pulse on a counter read. A spurious or missed wrap shows at the interrupt pin or the overflow pin one cycle after the 0xFF step. A corrupted clear-arming state shows only on the next keyed write: the flag either survives a proper read-then-clear sequence or falls without the read. The bench therefore exercises both orderings. State that standby corrupted shows on the first read of the control/status byte after standby ends.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W = 8;
  localparam int CKS_W = 3;
  localparam int NUM_TAPS = 1 << CKS_W;
  localparam logic [7:0] CTRL_KEY = 8'h5A;
  localparam logic ADDR_COUNT = 1'b0;
  localparam logic ADDR_CTRL  = 1'b1;

  typedef struct packed {
    logic             flag;
    logic             wdog;
    logic             run;
    logic [CKS_W-1:0] cks;
  } ctrl_t;

  function automatic logic [7:0] ctrl_image(ctrl_t c);
    return {c.flag, c.wdog, c.run, 2'b11, c.cks};
  endfunction

  function automatic logic [CNT_W-1:0] count_step(logic [CNT_W-1:0] v);
    return v + {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic count_at_top(logic [CNT_W-1:0] v);
    return &v;
  endfunction
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       standby,
  input  logic       wr_ok,
  input  logic [7:0] wbyte,
  input  logic       rd_ctrl,
  input  logic       flag_set,
  output ctrl_t      ctrl_q,
  output logic       clear_armed
);
  logic clear_req;

  assign clear_req = wr_ok & clear_armed & ~wbyte[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      clear_armed <= 1'b0;
    end else if (standby) begin
      ctrl_q.flag <= 1'b0;
      ctrl_q.wdog <= 1'b0;
      ctrl_q.run  <= 1'b0;
      clear_armed <= 1'b0;
    end else begin
      if (flag_set)       ctrl_q.flag <= 1'b1;
      else if (clear_req) ctrl_q.flag <= 1'b0;
      if (wr_ok) begin
        ctrl_q.wdog <= wbyte[6];
        ctrl_q.run  <= wbyte[5];
        ctrl_q.cks  <= wbyte[CKS_W-1:0];
        clear_armed <= 1'b0;
      end else if (rd_ctrl && ctrl_q.flag) begin
        clear_armed <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [CKS_W-1:0]    cks,
  input  logic [NUM_TAPS-1:0] taps,
  input  logic                load,
  input  logic [CNT_W-1:0]    load_val,
  output logic [CNT_W-1:0]    count,
  output logic                tick,
  output logic                wrap_evt
);
  assign tick     = run & taps[cks];
  assign wrap_evt = tick & ~load & count_at_top(count);

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else if (tick) count <= count_step(count);
  end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active
);
  localparam int PW = $clog2(LEN + 1);
  logic [PW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n)           remain <= '0;
    else if (fire)        remain <= PW'(LEN);
    else if (remain != 0) remain <= remain - 1'b1;
  end

  assign active = (remain != '0);
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int PULSE_LEN = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TAPS-1:0] clk_en_taps,
  input  logic                standby,
  input  logic                addr,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [15:0]         wdata,
  output logic [7:0]          rdata,
  output logic                irq_interval,
  output logic                wdt_ovf_out
);
  ctrl_t            ctrl_q;
  logic             clear_armed;
  logic             ctrl_wr_ok;
  logic             ctrl_wr_bad;
  logic             cnt_wr;
  logic             rd_ctrl;
  logic [CNT_W-1:0] count;
  logic             tick;
  logic             wrap_evt;
  logic             flag_set;
  logic             wdog_fire;
  logic             flag_q, wdog_q, run_q;
  logic [CKS_W-1:0] cks_q;

  assign ctrl_wr_ok  = wr_en & (addr == ADDR_CTRL) & (wdata[15:8] == CTRL_KEY) & ~standby;
  assign ctrl_wr_bad = wr_en & (addr == ADDR_CTRL) & (wdata[15:8] != CTRL_KEY);
  assign cnt_wr      = wr_en & (addr == ADDR_COUNT);
  assign rd_ctrl     = rd_en & (addr == ADDR_CTRL);

  assign flag_q = ctrl_q.flag;
  assign wdog_q = ctrl_q.wdog;
  assign run_q  = ctrl_q.run;
  assign cks_q  = ctrl_q.cks;

  assign flag_set  = wrap_evt & ~wdog_q;
  assign wdog_fire = wrap_evt & wdog_q;

  wdt_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .standby(standby),
    .wr_ok(ctrl_wr_ok), .wbyte(wdata[7:0]), .rd_ctrl(rd_ctrl),
    .flag_set(flag_set), .ctrl_q(ctrl_q), .clear_armed(clear_armed)
  );

  wdt_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run_q), .cks(cks_q),
    .taps(clk_en_taps), .load(cnt_wr), .load_val(wdata[CNT_W-1:0]),
    .count(count), .tick(tick), .wrap_evt(wrap_evt)
  );

  wdt_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(wdog_fire), .active(wdt_ovf_out)
  );

  assign irq_interval = flag_q & ~wdog_q;

  always_comb begin
    if (!rd_en)                 rdata = '0;
    else if (addr == ADDR_CTRL) rdata = ctrl_image(ctrl_q);
    else                        rdata = 8'(count);
  end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             standby,
  input logic             tick,
  input logic             wrap_evt,
  input logic             cnt_wr,
  input logic             ctrl_wr_bad,
  input logic [CNT_W-1:0] count,
  input logic             flag_q,
  input logic             wdog_q,
  input logic             run_q,
  input logic [CKS_W-1:0] cks_q,
  input logic             wdt_ovf_out
);
  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr) |=> (count == $past(count) + 1'b1));

  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cnt_wr) |=> $stable(count));

  assert_flag_on_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && !wdog_q && !standby) |=> flag_q);

  assert_no_flag_wdog_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wdog_q && !flag_q) |=> !flag_q);

  assert_pulse_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && wdog_q) |=> wdt_ovf_out);

  assert_bad_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr_bad && !wrap_evt && !standby) |=> $stable({flag_q, wdog_q, run_q, cks_q}));

  assert_standby_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (!flag_q && !wdog_q && !run_q && $stable(cks_q)));

  assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |-> !wrap_evt);
endmodule

bind wdt_top wdt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .standby(standby), .tick(tick),
  .wrap_evt(wrap_evt), .cnt_wr(cnt_wr), .ctrl_wr_bad(ctrl_wr_bad),
  .count(count), .flag_q(flag_q), .wdog_q(wdog_q), .run_q(run_q),
  .cks_q(cks_q), .wdt_ovf_out(wdt_ovf_out)
);

// File: tb/wdt_top_tb_top.sv
module wdt_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  taps = '0;
  logic        standby = 1'b0;
  logic        addr = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [7:0]  rdata;
  logic        irq;
  logic        wovf;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  wdt_top #(.PULSE_LEN(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en_taps(taps), .standby(standby),
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .rdata(rdata), .irq_interval(irq), .wdt_ovf_out(wovf)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse_taps(logic [7:0] pat, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); taps = pat;
      @(negedge clk); taps = '0;
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(1'b1, d); chk("R1 ctrl reset", 16'(d), 16'h18);
    rd(1'b0, d); chk("R1 count reset", 16'(d), 16'h00);
    chk("R1 irq reset", 16'(irq), 16'h0);
    chk("R1 ovf reset", 16'(wovf), 16'h0);
  endtask

  task automatic t_key;
    logic [7:0] d;
    wr(1'b1, 16'hA522);
    rd(1'b1, d); chk("R2 bad key ignored", 16'(d), 16'h18);
    wr(1'b1, 16'h5A22);
    rd(1'b1, d); chk("R2 keyed write", 16'(d), 16'h3A);
  endtask

  task automatic t_count;
    logic [7:0] d;
    pulse_taps(8'h04, 3);
    rd(1'b0, d); chk("R3 selected tap counts", 16'(d), 16'h03);
    pulse_taps(8'hFB, 2);
    rd(1'b0, d); chk("R3 other taps ignored", 16'(d), 16'h03);
    wr(1'b1, 16'h5A02);
    pulse_taps(8'h04, 2);
    rd(1'b0, d); chk("R4 hold while disabled", 16'(d), 16'h03);
    wr(1'b1, 16'h5A22);
  endtask

  task automatic t_interval;
    logic [7:0] d;
    wr(1'b0, 16'h00FE);
    pulse_taps(8'h04, 2);
    chk("R5 irq after wrap", 16'(irq), 16'h1);
    chk("R5 no wdog pulse", 16'(wovf), 16'h0);
    rd(1'b0, d); chk("R5 count wrapped", 16'(d), 16'h00);
  endtask

  task automatic t_clear;
    logic [7:0] d;
    wr(1'b1, 16'h5A22);
    chk("R7 no clear without read", 16'(irq), 16'h1);
    rd(1'b1, d); chk("R7 flag reads 1", 16'(d), 16'hBA);
    wr(1'b1, 16'h5A22);
    chk("R7 cleared after read", 16'(irq), 16'h0);
    wr(1'b1, 16'h5AA2);
    rd(1'b1, d); chk("R7 write 1 no set", 16'(d), 16'h3A);
  endtask

  task automatic t_wdog;
    logic [7:0] d;
    wr(1'b1, 16'h5A62);
    wr(1'b0, 16'h00FF);
    @(negedge clk); taps = 8'h04;
    @(negedge clk); taps = '0;
    for (int i = 0; i < 4; i++) begin
      chk("R6 pulse high", 16'(wovf), 16'h1);
      @(negedge clk);
    end
    chk("R6 pulse ends", 16'(wovf), 16'h0);
    chk("R6 no irq", 16'(irq), 16'h0);
    rd(1'b1, d); chk("R6 flag stays 0", 16'(d), 16'h7A);
  endtask

  task automatic t_load_wins;
    logic [7:0] d;
    wr(1'b1, 16'h5A22);
    wr(1'b0, 16'h00FF);
    @(negedge clk); addr = 1'b0; wdata = 16'h0010; wr_en = 1'b1; taps = 8'h04;
    @(negedge clk); wr_en = 1'b0; taps = '0;
    chk("R9 no wrap on load", 16'(irq), 16'h0);
    rd(1'b0, d); chk("R9 loaded value", 16'(d), 16'h10);
  endtask

  task automatic t_standby;
    logic [7:0] d;
    wr(1'b0, 16'h00FF);
    pulse_taps(8'h04, 1);
    chk("R8 flag set before standby", 16'(irq), 16'h1);
    @(negedge clk); standby = 1'b1; addr = 1'b1; wdata = 16'h5A47; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk); standby = 1'b0;
    rd(1'b1, d); chk("R8 upper cleared cks kept", 16'(d), 16'h1A);
    chk("R8 irq low", 16'(irq), 16'h0);
    pulse_taps(8'h04, 2);
    rd(1'b0, d); chk("R8 counter stopped", 16'(d), 16'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_key;
    t_count;
    t_interval;
    t_clear;
    t_wdog;
    t_load_wins;
    t_standby;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog timeout actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule